// File: doc/BRIEF.md
# Prebyte-aware instruction framer

This block sits between a program-byte source and the decode stage of an 8-bit accumulator CPU whose opcode space is spread over four pages. Bytes arrive one at a time on a valid/ready handshake. The framer absorbs an optional page-select byte, classifies the opcode on the selected page, and gathers the operand bytes that the opcode's addressing form calls for. When the instruction is complete, it presents it as one record.

Each record carries the page number, the opcode byte, the addressing mode, the total byte count including any page-select byte, up to three operand bytes, and a flag that marks an opcode with no defined meaning on its page. While a record is waiting for the consumer, the framer stops taking input. Once the record is taken, the framer returns to page 0 and waits for the next opcode.

Top module: `instr_framer`

## Requirements
- R1: A synchronous reset, including one asserted partway through an instruction, leaves `outValid` low and `inReady` high. The next byte is then decoded as a page-0 opcode.
- R2: On page 0 only, the bytes $18, $1A and $CD are page selects for pages 1, 2 and 3. They produce no record of their own. The byte that follows is decoded on the selected page, and `outPage` reports that page. The same values seen on pages 1 to 3 are treated as ordinary opcodes.
- R3: On page 0 the opcode's high nibble sets the mode. Nibbles 0, 1, 3, 4 and 5 give inherent (code 0). Nibble 2 gives relative (6) with one offset byte. Nibbles 6 and A give X-indexed (4) with one byte. Nibbles 7 and B give extended (3) with two bytes. Nibbles 8 and C give immediate (1). Nibbles 9 and D give direct (2) with one byte.
- R4: Page 0 has exceptions in the immediate columns. $8D is relative (6) with one byte. $8F and $CF are inherent with no operand. The 16-bit immediates $83, $8C, $8E, $C3, $CC and $CE take two bytes. All other immediates take one byte.
- R5: The bit set/clear opcodes $14 and $15 (direct) and $1C and $1D (X-indexed) take two operand bytes. The branch-on-bit opcodes $12 and $13 (direct) and $1E and $1F (X-indexed) take three. On page 1, $1C to $1F take the same counts with Y-indexed mode (5).
- R6: On page 1, columns 6, A and E report Y-indexed mode (5) with one byte. The other page-1 opcodes follow their page-0 counterparts: $8F is inherent, and $8C and $CE are 2-byte immediates.
- R7: Some opcodes are undefined on their page. Examples are $41, $42, $87 and $C7 on page 0, $6B on page 1, and any byte outside the defined sets of pages 2 and 3. Such an opcode sets `outIllegal`, reports mode 0 with no operands and a length of 1 (or 2 after a page select), and framing resumes at the next byte.
- R8: `outLength` equals 1, plus 1 if a page select came first, plus the operand count. The first operand byte sits in `outOperands[7:0]`, the second in `[15:8]` and the third in `[23:16]`. Unused operand bytes are zero.
- R9: While `outValid` is high and `outReady` is low, every record output holds its value and `inReady` stays low, so an offered byte is not consumed until the record has been taken.
- R10: Page 2 defines $83 (immediate, 2 bytes), $93 (direct), $B3 (extended), and $A3, $AC, $EE and $EF (X-indexed). Page 3 defines $A3, $AC, $EE and $EF, all Y-indexed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inByte | input | 8 | Program byte |
| inValid | input | 1 | Program byte is offered |
| inReady | output | 1 | Framer takes the offered byte this cycle |
| outValid | output | 1 | Complete instruction record is presented |
| outReady | input | 1 | Consumer takes the record this cycle |
| outPage | output | 2 | Opcode page, 0 to 3 |
| outOpcode | output | 8 | Opcode byte |
| outMode | output | 3 | Addressing mode code |
| outLength | output | 3 | Total instruction bytes, 1 to 5 |
| outOperands | output | 24 | Operand bytes, first in the low byte |
| outIllegal | output | 1 | Opcode undefined on its page |

## Verification
The hardest condition to create from the ports is a byte that is offered while a finished record is blocked. Only that case shows whether the framer leaves the byte in place or swallows it. The stimulus completes a record, keeps `outReady` low, and then raises `inValid` with a fresh opcode for several cycles. It checks that the record and `inReady` hold, releases the record, and expects the held byte to come out as the next instruction. A reset is also forced right after a page select, to show that the page state is dropped.

// File: rtl/framer_pkg.sv
package framer_pkg;
  localparam int BYTE_W  = 8;
  localparam int MAX_OPS = 3;
  localparam int PAGE_W  = 2;
  localparam int CNT_W   = $clog2(MAX_OPS + 1);
  localparam int LEN_W   = $clog2(MAX_OPS + 3);

  typedef enum logic [2:0] {
    MODE_INH  = 3'd0,
    MODE_IMM  = 3'd1,
    MODE_DIR  = 3'd2,
    MODE_EXT  = 3'd3,
    MODE_IDXX = 3'd4,
    MODE_IDXY = 3'd5,
    MODE_REL  = 3'd6
  } addrMode_t;

  typedef struct packed {
    logic              legal;
    logic              isPrefix;
    logic [PAGE_W-1:0] prefixPage;
    addrMode_t         mode;
    logic [CNT_W-1:0]  nOps;
  } decode_t;

  typedef struct packed {
    logic setPage;
    logic loadOpc;
    logic loadOpnd;
    logic clear;
  } strobe_t;

  // holes in the page-0 accumulator inherent columns
  function automatic logic gapInh(input logic [3:0] lo);
    return lo inside {4'h1, 4'h2, 4'h5, 4'hB, 4'hE};
  endfunction

  // holes in the page-0 memory read-modify-write columns
  function automatic logic gapMem(input logic [3:0] lo);
    return lo inside {4'h1, 4'h2, 4'h5, 4'hB};
  endfunction

  // rows holding 16-bit immediate operands
  function automatic logic wideImm(input logic [3:0] lo);
    return lo inside {4'h3, 4'hC, 4'hE};
  endfunction
endpackage

// File: rtl/instr_decoder.sv
module instr_decoder
  import framer_pkg::*;
(
  input  logic [PAGE_W-1:0] page,
  input  logic [BYTE_W-1:0] opByte,
  output decode_t           dec
);
  logic [3:0] hi;
  logic [3:0] lo;
  assign hi = opByte[7:4];
  assign lo = opByte[3:0];

  always_comb begin
    dec = '{legal: 1'b0, isPrefix: 1'b0, prefixPage: '0, mode: MODE_INH, nOps: '0};
    unique case (page)
      2'd0: begin
        dec.legal = 1'b1;
        case (hi)
          4'h1: begin
            case (lo)
              4'h2, 4'h3: begin dec.mode = MODE_DIR;  dec.nOps = 2'd3; end
              4'h4, 4'h5: begin dec.mode = MODE_DIR;  dec.nOps = 2'd2; end
              4'hC, 4'hD: begin dec.mode = MODE_IDXX; dec.nOps = 2'd2; end
              4'hE, 4'hF: begin dec.mode = MODE_IDXX; dec.nOps = 2'd3; end
              4'h8: begin dec.legal = 1'b0; dec.isPrefix = 1'b1; dec.prefixPage = 2'd1; end
              4'hA: begin dec.legal = 1'b0; dec.isPrefix = 1'b1; dec.prefixPage = 2'd2; end
              default: ;
            endcase
          end
          4'h2: begin dec.mode = MODE_REL; dec.nOps = 2'd1; end
          4'h4, 4'h5: dec.legal = !gapInh(lo);
          4'h6: begin dec.legal = !gapMem(lo); dec.mode = MODE_IDXX; dec.nOps = 2'd1; end
          4'h7: begin dec.legal = !gapMem(lo); dec.mode = MODE_EXT;  dec.nOps = 2'd2; end
          4'h8, 4'hC: begin
            if (lo == 4'h7) begin
              dec.legal = 1'b0;
            end else if (lo == 4'hD) begin
              if (hi == 4'h8) begin
                dec.mode = MODE_REL;
                dec.nOps = 2'd1;
              end else begin
                dec.legal      = 1'b0;
                dec.isPrefix   = 1'b1;
                dec.prefixPage = 2'd3;
              end
            end else if (lo != 4'hF) begin
              dec.mode = MODE_IMM;
              dec.nOps = wideImm(lo) ? 2'd2 : 2'd1;
            end
          end
          4'h9, 4'hD: begin dec.mode = MODE_DIR;  dec.nOps = 2'd1; end
          4'hA, 4'hE: begin dec.mode = MODE_IDXX; dec.nOps = 2'd1; end
          4'hB, 4'hF: begin dec.mode = MODE_EXT;  dec.nOps = 2'd2; end
          default: ;
        endcase
      end
      2'd1: begin
        case (hi)
          4'h0: dec.legal = (lo == 4'h8) || (lo == 4'h9);
          4'h1: begin
            if (lo inside {4'hC, 4'hD}) begin
              dec.legal = 1'b1; dec.mode = MODE_IDXY; dec.nOps = 2'd2;
            end else if (lo inside {4'hE, 4'hF}) begin
              dec.legal = 1'b1; dec.mode = MODE_IDXY; dec.nOps = 2'd3;
            end
          end
          4'h3: dec.legal = lo inside {4'h0, 4'h5, 4'h8, 4'hA, 4'hC};
          4'h6: begin dec.legal = !gapMem(lo); dec.mode = MODE_IDXY; dec.nOps = 2'd1; end
          4'h8: begin
            if (lo == 4'hC) begin dec.legal = 1'b1; dec.mode = MODE_IMM; dec.nOps = 2'd2; end
            else if (lo == 4'hF) dec.legal = 1'b1;
          end
          4'h9: if (lo == 4'hC) begin dec.legal = 1'b1; dec.mode = MODE_DIR; dec.nOps = 2'd1; end
          4'hB: if (lo == 4'hC) begin dec.legal = 1'b1; dec.mode = MODE_EXT; dec.nOps = 2'd2; end
          4'hC: if (lo == 4'hE) begin dec.legal = 1'b1; dec.mode = MODE_IMM; dec.nOps = 2'd2; end
          4'hD: if (lo inside {4'hE, 4'hF}) begin dec.legal = 1'b1; dec.mode = MODE_DIR; dec.nOps = 2'd1; end
          4'hF: if (lo inside {4'hE, 4'hF}) begin dec.legal = 1'b1; dec.mode = MODE_EXT; dec.nOps = 2'd2; end
          4'hA, 4'hE: begin dec.legal = 1'b1; dec.mode = MODE_IDXY; dec.nOps = 2'd1; end
          default: ;
        endcase
      end
      2'd2: begin
        case (opByte)
          8'h83: begin dec.legal = 1'b1; dec.mode = MODE_IMM; dec.nOps = 2'd2; end
          8'h93: begin dec.legal = 1'b1; dec.mode = MODE_DIR; dec.nOps = 2'd1; end
          8'hB3: begin dec.legal = 1'b1; dec.mode = MODE_EXT; dec.nOps = 2'd2; end
          8'hA3, 8'hAC, 8'hEE, 8'hEF: begin
            dec.legal = 1'b1; dec.mode = MODE_IDXX; dec.nOps = 2'd1;
          end
          default: ;
        endcase
      end
      2'd3: begin
        case (opByte)
          8'hA3, 8'hAC, 8'hEE, 8'hEF: begin
            dec.legal = 1'b1; dec.mode = MODE_IDXY; dec.nOps = 2'd1;
          end
          default: ;
        endcase
      end
    endcase
    if (!dec.legal) begin
      dec.mode = MODE_INH;
      dec.nOps = '0;
    end
  end
endmodule

// File: rtl/framer_ctrl.sv
module framer_ctrl
  import framer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             inValid,
  input  logic             outReady,
  input  decode_t          dec,
  input  logic [CNT_W-1:0] opndCnt,
  input  logic [CNT_W-1:0] needOps,
  output logic             inReady,
  output logic             outValid,
  output strobe_t          stb
);
  typedef enum logic [1:0] {ST_OPC, ST_OPND, ST_HOLD} state_t;
  state_t state;
  state_t nextState;
  logic   accept;

  assign inReady  = (state != ST_HOLD);
  assign outValid = (state == ST_HOLD);
  assign accept   = inValid && inReady;

  always_comb begin
    stb       = '0;
    nextState = state;
    unique case (state)
      ST_OPC: begin
        if (accept) begin
          if (dec.isPrefix) begin
            stb.setPage = 1'b1;
          end else begin
            stb.loadOpc = 1'b1;
            nextState   = (dec.nOps == '0) ? ST_HOLD : ST_OPND;
          end
        end
      end
      ST_OPND: begin
        if (accept) begin
          stb.loadOpnd = 1'b1;
          if ((opndCnt + CNT_W'(1)) == needOps) nextState = ST_HOLD;
        end
      end
      ST_HOLD: begin
        if (outReady) begin
          stb.clear = 1'b1;
          nextState = ST_OPC;
        end
      end
      default: nextState = ST_OPC;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OPC;
    else     state <= nextState;
  end
endmodule

// File: rtl/framer_datapath.sv
module framer_datapath
  import framer_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst,
  input  logic [BYTE_W-1:0]          inByte,
  input  decode_t                    dec,
  input  strobe_t                    stb,
  output logic [PAGE_W-1:0]          page,
  output logic [BYTE_W-1:0]          opcode,
  output addrMode_t                  mode,
  output logic                       illegal,
  output logic [CNT_W-1:0]           opndCnt,
  output logic [CNT_W-1:0]           needOps,
  output logic [LEN_W-1:0]           length,
  output logic [MAX_OPS*BYTE_W-1:0]  operands
);
  logic [BYTE_W-1:0] opnd [MAX_OPS];
  logic              wipe;
  assign wipe = rst || stb.clear;

  always_ff @(posedge clk) begin
    if (wipe) begin
      page    <= '0;
      opcode  <= '0;
      mode    <= MODE_INH;
      illegal <= 1'b0;
      opndCnt <= '0;
      needOps <= '0;
    end else begin
      if (stb.setPage) page <= dec.prefixPage;
      if (stb.loadOpc) begin
        opcode  <= inByte;
        mode    <= dec.mode;
        illegal <= !dec.legal;
        needOps <= dec.nOps;
        opndCnt <= '0;
      end
      if (stb.loadOpnd) opndCnt <= opndCnt + CNT_W'(1);
    end
  end

  for (genvar g = 0; g < MAX_OPS; g++) begin : gOpnd
    always_ff @(posedge clk) begin
      if (wipe || stb.loadOpc)                       opnd[g] <= '0;
      else if (stb.loadOpnd && opndCnt == CNT_W'(g)) opnd[g] <= inByte;
    end
    assign operands[g*BYTE_W +: BYTE_W] = opnd[g];
  end

  assign length = LEN_W'(1) + LEN_W'(page != '0) + LEN_W'(needOps);
endmodule

// File: rtl/instr_framer.sv
module instr_framer
  import framer_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst,
  input  logic [BYTE_W-1:0]         inByte,
  input  logic                      inValid,
  output logic                      inReady,
  output logic                      outValid,
  input  logic                      outReady,
  output logic [PAGE_W-1:0]         outPage,
  output logic [BYTE_W-1:0]         outOpcode,
  output logic [2:0]                outMode,
  output logic [LEN_W-1:0]          outLength,
  output logic [MAX_OPS*BYTE_W-1:0] outOperands,
  output logic                      outIllegal
);
  decode_t          dec;
  strobe_t          stb;
  addrMode_t        modeReg;
  logic [CNT_W-1:0] opndCnt;
  logic [CNT_W-1:0] needOps;

  instr_decoder u_dec (
    .page   (outPage),
    .opByte (inByte),
    .dec    (dec)
  );

  framer_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .outReady (outReady),
    .dec      (dec),
    .opndCnt  (opndCnt),
    .needOps  (needOps),
    .inReady  (inReady),
    .outValid (outValid),
    .stb      (stb)
  );

  framer_datapath u_dp (
    .clk      (clk),
    .rst      (rst),
    .inByte   (inByte),
    .dec      (dec),
    .stb      (stb),
    .page     (outPage),
    .opcode   (outOpcode),
    .mode     (modeReg),
    .illegal  (outIllegal),
    .opndCnt  (opndCnt),
    .needOps  (needOps),
    .length   (outLength),
    .operands (outOperands)
  );

  assign outMode = modeReg;
endmodule

// File: rtl/instr_framer_chk.sv
module instr_framer_chk (
  input logic        clk,
  input logic        rst,
  input logic        inReady,
  input logic        outValid,
  input logic        outReady,
  input logic [1:0]  outPage,
  input logic [7:0]  outOpcode,
  input logic [2:0]  outMode,
  input logic [2:0]  outLength,
  input logic [23:0] outOperands,
  input logic        outIllegal
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!outValid && inReady));

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outReady) |=> (outValid &&
      $stable({outPage, outOpcode, outMode, outLength, outOperands, outIllegal})));

  // R9
  no_take_while_full_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> !inReady);

  // R7
  illegal_shape_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outIllegal) |->
      (outLength == ((outPage == 2'd0) ? 3'd1 : 3'd2) && outOperands == 24'd0 && outMode == 3'd0));

  // R8
  length_range_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outLength >= 3'd1 && outLength <= 3'd5));

  // R2
  prefixed_len_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outPage != 2'd0) |-> (outLength >= 3'd2));

  // R10
  page3_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !outIllegal && outPage == 2'd3) |-> (outMode == 3'd5));
endmodule

bind instr_framer instr_framer_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .inReady     (inReady),
  .outValid    (outValid),
  .outReady    (outReady),
  .outPage     (outPage),
  .outOpcode   (outOpcode),
  .outMode     (outMode),
  .outLength   (outLength),
  .outOperands (outOperands),
  .outIllegal  (outIllegal)
);

// File: tb/test_instr_framer.sv
`timescale 1ns/1ps
module test_instr_framer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  inByte = 8'h00;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [1:0]  outPage;
  logic [7:0]  outOpcode;
  logic [2:0]  outMode;
  logic [2:0]  outLength;
  logic [23:0] outOperands;
  logic        outIllegal;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  instr_framer i_instr_framer (
    .clk(clk), .rst(rst), .inByte(inByte), .inValid(inValid), .inReady(inReady),
    .outValid(outValid), .outReady(outReady), .outPage(outPage), .outOpcode(outOpcode),
    .outMode(outMode), .outLength(outLength), .outOperands(outOperands),
    .outIllegal(outIllegal)
  );

  typedef struct packed {
    logic [39:0] bytes;
    logic [1:0]  page;
    logic [7:0]  opc;
    logic [2:0]  mode;
    logic [2:0]  len;
    logic [23:0] ops;
    logic        ill;
    logic [3:0]  req;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t VECS [NVEC] = '{
    '{40'h0100000000, 2'd0, 8'h01, 3'd0, 3'd1, 24'h000000, 1'b0, 4'd3},  // R3 inherent
    '{40'h207F000000, 2'd0, 8'h20, 3'd6, 3'd2, 24'h00007F, 1'b0, 4'd3},  // R3 relative
    '{40'h8655000000, 2'd0, 8'h86, 3'd1, 3'd2, 24'h000055, 1'b0, 4'd4},  // R4 narrow imm
    '{40'hCE12340000, 2'd0, 8'hCE, 3'd1, 3'd3, 24'h003412, 1'b0, 4'd8},  // R8 packing
    '{40'h8D10000000, 2'd0, 8'h8D, 3'd6, 3'd2, 24'h000010, 1'b0, 4'd4},  // R4 $8D
    '{40'hCF00000000, 2'd0, 8'hCF, 3'd0, 3'd1, 24'h000000, 1'b0, 4'd4},  // R4 $CF
    '{40'h9640000000, 2'd0, 8'h96, 3'd2, 3'd2, 24'h000040, 1'b0, 4'd3},  // R3 direct
    '{40'hB612340000, 2'd0, 8'hB6, 3'd3, 3'd3, 24'h003412, 1'b0, 4'd3},  // R3 extended
    '{40'hA605000000, 2'd0, 8'hA6, 3'd4, 3'd2, 24'h000005, 1'b0, 4'd3},  // R3 indexed
    '{40'h12400F0800, 2'd0, 8'h12, 3'd2, 3'd4, 24'h080F40, 1'b0, 4'd5},  // R5 branch on bit
    '{40'h1D03800000, 2'd0, 8'h1D, 3'd4, 3'd3, 24'h008003, 1'b0, 4'd5},  // R5 bit clear
    '{40'h181E0401FC, 2'd1, 8'h1E, 3'd5, 3'd5, 24'hFC0104, 1'b0, 4'd5},  // R5 five bytes
    '{40'h18A6020000, 2'd1, 8'hA6, 3'd5, 3'd3, 24'h000002, 1'b0, 4'd6},  // R6 Y indexed
    '{40'h18CEABCD00, 2'd1, 8'hCE, 3'd1, 3'd4, 24'h00CDAB, 1'b0, 4'd2},  // R2 page 1
    '{40'h1A83000100, 2'd2, 8'h83, 3'd1, 3'd4, 24'h000100, 1'b0, 4'd10}, // R10 page 2
    '{40'hCDEE070000, 2'd3, 8'hEE, 3'd5, 3'd3, 24'h000007, 1'b0, 4'd10}, // R10 page 3
    '{40'h4200000000, 2'd0, 8'h42, 3'd0, 3'd1, 24'h000000, 1'b1, 4'd7},  // R7
    '{40'h1A00000000, 2'd2, 8'h00, 3'd0, 3'd2, 24'h000000, 1'b1, 4'd7},  // R7 after select
    '{40'h8700000000, 2'd0, 8'h87, 3'd0, 3'd1, 24'h000000, 1'b1, 4'd7},  // R7
    '{40'h3D00000000, 2'd0, 8'h3D, 3'd0, 3'd1, 24'h000000, 1'b0, 4'd3},  // R3
    '{40'h186B000000, 2'd1, 8'h6B, 3'd0, 3'd2, 24'h000000, 1'b1, 4'd7},  // R7 page 1 hole
    '{40'hCD18000000, 2'd3, 8'h18, 3'd0, 3'd2, 24'h000000, 1'b1, 4'd2},  // R2 no select off page 0
    '{40'h188F000000, 2'd1, 8'h8F, 3'd0, 3'd2, 24'h000000, 1'b0, 4'd6},  // R6 inherent
    '{40'h1AB3123400, 2'd2, 8'hB3, 3'd3, 3'd4, 24'h003412, 1'b0, 4'd10}  // R10 extended
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inByte  = b;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    #1 inValid = 1'b0;
  endtask

  task automatic expectInstr(input logic [1:0] p, input logic [7:0] op, input logic [2:0] md,
                             input logic [2:0] ln, input logic [23:0] ops, input logic il,
                             input string tag);
    int wait_n = 0;
    @(negedge clk);
    while (!outValid && wait_n < 50) begin
      @(negedge clk);
      wait_n++;
    end
    check(outValid && outPage == p && outOpcode == op && outMode == md && outLength == ln &&
          outOperands == ops && outIllegal == il, tag,
          {outValid, 5'd0, outPage, outOpcode, 5'd0, outMode, 5'd0, outLength, outOperands, 7'd0, outIllegal},
          {1'b1,     5'd0, p,       op,        5'd0, md,      5'd0, ln,        ops,         7'd0, il});
    outReady = 1'b1;
    @(posedge clk);
    #1 outReady = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!outValid && inReady, "R1 reset idle", {62'd0, outValid, inReady}, 64'd1);

    for (int v = 0; v < NVEC; v++) begin
      for (int k = 0; k < int'(VECS[v].len); k++) sendByte(VECS[v].bytes[39 - 8*k -: 8]);
      expectInstr(VECS[v].page, VECS[v].opc, VECS[v].mode, VECS[v].len, VECS[v].ops,
                  VECS[v].ill, $sformatf("R%0d vector %0d", VECS[v].req, v));
    end

    // R9 backpressure: record held, offered byte left pending
    sendByte(8'h86);
    sendByte(8'h55);
    @(negedge clk);
    while (!outValid) @(negedge clk);
    inByte  = 8'h01;
    inValid = 1'b1;
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      check(outValid && !inReady && outOpcode == 8'h86 && outOperands == 24'h55 && outLength == 3'd2,
            "R9 hold", {30'd0, outValid, inReady, outOpcode, outOperands}, {30'd0, 1'b1, 1'b0, 8'h86, 24'h55});
    end
    outReady = 1'b1;
    @(posedge clk);
    #1 outReady = 1'b0;
    @(negedge clk);
    check(inReady, "R9 ready after take", {63'd0, inReady}, 64'd1);
    @(posedge clk);
    #1 inValid = 1'b0;
    expectInstr(2'd0, 8'h01, 3'd0, 3'd1, 24'h0, 1'b0, "R9 pending byte framed");

    // R1 reset after a page select drops the page
    sendByte(8'h18);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!outValid && inReady, "R1 mid reset idle", {62'd0, outValid, inReady}, 64'd1);
    sendByte(8'h08);
    expectInstr(2'd0, 8'h08, 3'd0, 3'd1, 24'h0, 1'b0, "R1 page 0 after reset");

    // R7 framing resumes right after an illegal byte
    sendByte(8'hC7);
    expectInstr(2'd0, 8'hC7, 3'd0, 3'd1, 24'h0, 1'b1, "R7 C7 illegal");
    sendByte(8'hCC);
    sendByte(8'hBE);
    sendByte(8'hEF);
    expectInstr(2'd0, 8'hCC, 3'd1, 3'd3, 24'h00EFBE, 1'b0, "R4 wide imm after illegal");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule